// File: doc/BRIEF.md
# CE-ATA Completion Signal Handler

This block is a small sub-controller inside the command path of an SD/MMC host. When the host issues a command flagged as expecting a completion signal, the block enters a wait and watches the sampled CMD line. The card reports that the command has finished by pulling CMD low. The wait has no time limit and no hardware timer. Software decides when to abort by raising a disable request. The block then drives a short disable pattern onto CMD. If software asks for it, the block follows the pattern with a stop-transmission request (CMD12) to an external command sender, using a valid/ready handshake.

The block reports three events as raw status bits. Each bit is write-1-to-clear and has its own enable. A single interrupt output is the OR of the enabled raw bits. The block has five named states:

- ST_IDLE: no wait in progress.
- ST_WAIT_CCS: waiting for the completion signal.
- ST_SEND_CCSD: shifting the disable pattern onto CMD.
- ST_STOP_REQ: offering the CMD12 request.
- ST_STOP_WAIT: waiting for the sender to report that CMD12 is done.

The transitions are:

- ST_IDLE to ST_WAIT_CCS on a flagged command start.
- ST_WAIT_CCS to ST_IDLE on a low CMD sample.
- ST_WAIT_CCS to ST_SEND_CCSD on a disable request while CMD is high.
- ST_SEND_CCSD to ST_IDLE, or to ST_STOP_REQ when the automatic stop is enabled, on the last pattern bit.
- ST_STOP_REQ to ST_STOP_WAIT when the sender accepts.
- ST_STOP_WAIT to ST_IDLE when the sender reports done.

Top module: `ccs_handler`

## Requirements
- R1: After reset, raw_status is 0, irq is 0, cmd_oe is 0 and stop_valid is 0.
- R2: After cmd_start with ccs_expected=1, the block waits for any number of cycles while cmd_in stays high. During this wait it sets no status bit and does not drive CMD.
- R3: While waiting, a low cmd_in sampled on a clock edge sets raw_status bit 1 (data-transfer-over) at that edge, and the block returns to idle. A later low cmd_in in idle sets nothing.
- R4: When send_ccsd is high while waiting and cmd_in is high, the block drives cmd_oe for exactly 5 cycles starting at the next edge. During those cycles cmd_out carries 0,0,0,0,1 in that order. At the edge that releases cmd_oe, raw_status bit 0 (command-done) is set.
- R5: When send_ccsd is high in the same cycle that a low cmd_in is sampled while waiting, no pattern is driven. Raw_status bits 0 and 1 are both set at that edge.
- R6: When send_ccsd is high in idle, for example after the completion signal has already arrived, it has no effect: cmd_oe stays 0 and no status bit is set.
- R7: When auto_stop is high at the end of the pattern, stop_valid rises at the edge that releases cmd_oe. It stays high until an edge with stop_ready high. Raw_status bit 2 (auto-command-done) is set at the edge where stop_done is high.
- R8: A cmd_start with ccs_expected=0 starts no wait, so a low cmd_in sets nothing. In any state, xfer_done sets raw_status bit 1.
- R9: A 1 in status_clr clears the matching raw bit at the next edge. When a set and a clear of the same bit arrive in the same cycle, the set wins.
- R10: irq is high exactly when some raw_status bit is 1 and its irq_en bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-side clock; CMD is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle pulse when a command is issued |
| ccs_expected | input | 1 | Qualifies cmd_start: the command expects a completion signal |
| cmd_in | input | 1 | Sampled CMD line |
| send_ccsd | input | 1 | Software request to send the disable pattern (level) |
| auto_stop | input | 1 | Append CMD12 after the disable pattern |
| xfer_done | input | 1 | Data path reports that the requested byte count has moved |
| stop_ready | input | 1 | Command sender accepts the CMD12 request |
| stop_done | input | 1 | Command sender has finished CMD12 |
| status_clr | input | 3 | Write-1-to-clear strobes for raw_status |
| irq_en | input | 3 | Interrupt enable per raw bit |
| cmd_out | output | 1 | CMD drive value |
| cmd_oe | output | 1 | CMD output enable |
| stop_valid | output | 1 | CMD12 request to the command sender |
| raw_status | output | 3 | Bit 0 command-done, bit 1 data-transfer-over, bit 2 auto-command-done |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state shows up at the ports quickly. If the machine leaves the wait too early, data-transfer-over is missing after the next low CMD sample. If it leaves too late, a spurious bit appears one cycle after a low sample. A miscounted or misloaded shifter changes the cmd_out sequence, or the length of cmd_oe, within five cycles of the request. The same-cycle resolution is checked in a single edge: cmd_oe must stay low while both status bits appear. The handshake state is visible through stop_valid, which the bench holds against a stalled ready.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CCS,
        ST_SEND_CCSD,
        ST_STOP_REQ,
        ST_STOP_WAIT
    } ccs_state_t;

    localparam int STAT_W       = 3;
    localparam int BIT_CMD_DONE = 0;
    localparam int BIT_DTO      = 1;
    localparam int BIT_ACD      = 2;

endpackage

// File: rtl/ccsd_shifter.sv
module ccsd_shifter #(
    parameter int             LEN     = 5,
    parameter logic [LEN-1:0] PATTERN = 5'b00001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic drive_oe,
    output logic drive_bit,
    output logic last
);
    localparam int CNT_W = $clog2(LEN + 1);

    logic [LEN-1:0]   sh_q;
    logic [CNT_W-1:0] cnt_q;

    // Load the pattern, then send it most significant bit first.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= PATTERN;
            cnt_q <= CNT_W'(LEN);
        end else if (cnt_q != '0) begin
            sh_q  <= {sh_q[LEN-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        drive_oe  = (cnt_q != '0);
        drive_bit = sh_q[LEN-1];
        last      = (cnt_q == CNT_W'(1));
    end

endmodule

// File: rtl/ccs_fsm.sv
module ccs_fsm
    import ccs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       ccs_expected,
    input  logic       cmd_in,
    input  logic       send_ccsd,
    input  logic       auto_stop,
    input  logic       ccsd_last,
    input  logic       stop_ready,
    input  logic       stop_done,
    output ccs_state_t state,
    output logic       ccsd_load,
    output logic       stop_valid,
    output logic       set_dto,
    output logic       set_cmd_done,
    output logic       set_acd
);
    ccs_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      if (cmd_start && ccs_expected) state_nxt = ST_WAIT_CCS;
            ST_WAIT_CCS: begin
                if (!cmd_in)        state_nxt = ST_IDLE;
                else if (send_ccsd) state_nxt = ST_SEND_CCSD;
            end
            ST_SEND_CCSD: if (ccsd_last) state_nxt = auto_stop ? ST_STOP_REQ : ST_IDLE;
            ST_STOP_REQ:  if (stop_ready) state_nxt = ST_STOP_WAIT;
            ST_STOP_WAIT: if (stop_done)  state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // Outputs: a low sample wins over a disable request in the same cycle.
    always_comb begin
        ccsd_load    = 1'b0;
        stop_valid   = 1'b0;
        set_dto      = 1'b0;
        set_cmd_done = 1'b0;
        set_acd      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT_CCS: begin
                set_dto      = !cmd_in;
                set_cmd_done = !cmd_in && send_ccsd;
                ccsd_load    = cmd_in && send_ccsd;
            end
            ST_SEND_CCSD: set_cmd_done = ccsd_last;
            ST_STOP_REQ:  stop_valid   = 1'b1;
            ST_STOP_WAIT: set_acd      = stop_done;
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_status.sv
module irq_status #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] en,
    output logic [W-1:0] raw,
    output logic         irq
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      raw[i] <= 1'b0;
            else if (set[i]) raw[i] <= 1'b1;
            else if (clr[i]) raw[i] <= 1'b0;
        end
    end

    assign irq = |(raw & en);

endmodule

// File: rtl/ccs_handler.sv
module ccs_handler
    import ccs_pkg::*;
#(
    parameter int                  CCSD_LEN     = 5,
    parameter logic [CCSD_LEN-1:0] CCSD_PATTERN = 5'b00001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              ccs_expected,
    input  logic              cmd_in,
    input  logic              send_ccsd,
    input  logic              auto_stop,
    input  logic              xfer_done,
    input  logic              stop_ready,
    input  logic              stop_done,
    input  logic [STAT_W-1:0] status_clr,
    input  logic [STAT_W-1:0] irq_en,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              stop_valid,
    output logic [STAT_W-1:0] raw_status,
    output logic              irq
);
    ccs_state_t        fsm_state;
    logic              ccsd_load, ccsd_last;
    logic              set_dto_ccs, set_cmd_done, set_acd;
    logic [STAT_W-1:0] stat_set;

    ccs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .ccs_expected (ccs_expected),
        .cmd_in       (cmd_in),
        .send_ccsd    (send_ccsd),
        .auto_stop    (auto_stop),
        .ccsd_last    (ccsd_last),
        .stop_ready   (stop_ready),
        .stop_done    (stop_done),
        .state        (fsm_state),
        .ccsd_load    (ccsd_load),
        .stop_valid   (stop_valid),
        .set_dto      (set_dto_ccs),
        .set_cmd_done (set_cmd_done),
        .set_acd      (set_acd)
    );

    ccsd_shifter #(
        .LEN     (CCSD_LEN),
        .PATTERN (CCSD_PATTERN)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ccsd_load),
        .drive_oe  (cmd_oe),
        .drive_bit (cmd_out),
        .last      (ccsd_last)
    );

    always_comb begin
        stat_set               = '0;
        stat_set[BIT_CMD_DONE] = set_cmd_done;
        stat_set[BIT_DTO]      = set_dto_ccs | xfer_done;
        stat_set[BIT_ACD]      = set_acd;
    end

    irq_status #(.W(STAT_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stat_set),
        .clr   (status_clr),
        .en    (irq_en),
        .raw   (raw_status),
        .irq   (irq)
    );

endmodule

// File: rtl/ccs_handler_chk.sv
module ccs_handler_chk
    import ccs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input ccs_state_t st,
    input logic       cmd_in,
    input logic       send_ccsd,
    input logic       cmd_oe,
    input logic       cmd_out,
    input logic       stop_valid,
    input logic       stop_ready,
    input logic       stop_done,
    input logic [2:0] raw_status
);
    p_oe_in_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> (st == ST_SEND_CCSD));

    p_first_bit_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);

    p_done_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> raw_status[0]);

    p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_CCS && !cmd_in && send_ccsd) |=> (!cmd_oe && raw_status[0] && raw_status[1]));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !cmd_oe);

    p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_valid && !stop_ready) |=> stop_valid);

    p_acd_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_status[2]) |-> $past(stop_done));

endmodule

bind ccs_handler ccs_handler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (fsm_state),
    .cmd_in     (cmd_in),
    .send_ccsd  (send_ccsd),
    .cmd_oe     (cmd_oe),
    .cmd_out    (cmd_out),
    .stop_valid (stop_valid),
    .stop_ready (stop_ready),
    .stop_done  (stop_done),
    .raw_status (raw_status)
);

// File: tb/ccs_handler_test.sv
`timescale 1ns/1ps
module ccs_handler_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, ccs_expected = 0, cmd_in = 1, send_ccsd = 0, auto_stop = 0;
    logic xfer_done = 0, stop_ready = 0, stop_done = 0;
    logic [2:0] status_clr = '0, irq_en = '0;
    logic cmd_out, cmd_oe, stop_valid, irq;
    logic [2:0] raw_status;

    int checks = 0;
    int errors = 0;
    localparam logic [4:0] PAT = 5'b00001;

    always #2 clk = ~clk;

    ccs_handler uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .ccs_expected(ccs_expected),
        .cmd_in(cmd_in), .send_ccsd(send_ccsd), .auto_stop(auto_stop), .xfer_done(xfer_done),
        .stop_ready(stop_ready), .stop_done(stop_done), .status_clr(status_clr), .irq_en(irq_en),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .stop_valid(stop_valid),
        .raw_status(raw_status), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        status_clr = 3'b111; step(); status_clr = '0;
    endtask

    task automatic issue(input logic exp_ccs);
        cmd_start = 1; ccs_expected = exp_ccs; step(); cmd_start = 0; ccs_expected = 0;
    endtask

    task automatic t_reset();
        check("R1 raw", {5'd0, raw_status}, 8'd0);
        check("R1 oe/valid/irq", {5'd0, cmd_oe, stop_valid, irq}, 8'd0);
    endtask

    task automatic t_ccs();
        logic bad;
        clear_all();
        issue(1);
        bad = 0;
        for (int i = 0; i < 50; i++) begin
            step();
            if (raw_status != 0 || cmd_oe) bad = 1;
        end
        check("R2 long wait quiet", {7'd0, bad}, 8'd0);
        cmd_in = 0; step(); cmd_in = 1;
        check("R3 ccs sets dto", {5'd0, raw_status}, 8'h02);
        status_clr = 3'b010; step(); status_clr = 0;
        cmd_in = 0; step(); cmd_in = 1; step();
        check("R3 back to idle", {5'd0, raw_status}, 8'h00);
    endtask

    task automatic t_ccsd();
        clear_all();
        issue(1);
        send_ccsd = 1;
        for (int i = 0; i < 5; i++) begin
            step();
            check("R4 oe during pattern", {7'd0, cmd_oe}, 8'd1);
            check("R4 pattern bit", {7'd0, cmd_out}, {7'd0, PAT[4-i]});
            check("R4 no done yet", {7'd0, raw_status[0]}, 8'd0);
        end
        send_ccsd = 0;
        step();
        check("R4 release and done", {4'd0, cmd_oe, raw_status}, 8'h01);
        check("R4 no stop", {7'd0, stop_valid}, 8'd0);
    endtask

    task automatic t_same_cycle();
        logic bad;
        clear_all();
        issue(1);
        cmd_in = 0; send_ccsd = 1; step(); cmd_in = 1; send_ccsd = 0;
        check("R5 both set, no drive", {4'd0, cmd_oe, raw_status}, 8'h03);
        bad = 0;
        for (int i = 0; i < 6; i++) begin step(); if (cmd_oe) bad = 1; end
        check("R5 no pattern later", {7'd0, bad}, 8'd0);
    endtask

    task automatic t_late_ccsd();
        logic bad;
        clear_all();
        issue(1);
        cmd_in = 0; step(); cmd_in = 1;
        send_ccsd = 1;
        bad = 0;
        for (int i = 0; i < 10; i++) begin step(); if (cmd_oe) bad = 1; end
        send_ccsd = 0;
        check("R6 no drive in idle", {7'd0, bad}, 8'd0);
        check("R6 no cmd_done", {5'd0, raw_status}, 8'h02);
    endtask

    task automatic t_autostop();
        clear_all();
        auto_stop = 1;
        issue(1);
        send_ccsd = 1;
        for (int i = 0; i < 5; i++) step();
        send_ccsd = 0;
        step();
        check("R7 stop_valid after pattern", {6'd0, stop_valid, cmd_oe}, 8'h02);
        check("R7 cmd_done set", {7'd0, raw_status[0]}, 8'd1);
        for (int i = 0; i < 3; i++) step();
        check("R7 stop_valid held", {7'd0, stop_valid}, 8'd1);
        stop_ready = 1; step(); stop_ready = 0;
        check("R7 valid drops on accept", {6'd0, stop_valid, raw_status[2]}, 8'd0);
        step(); step();
        stop_done = 1; step(); stop_done = 0;
        check("R7 acd set", {5'd0, raw_status}, 8'h05);
        auto_stop = 0;
    endtask

    task automatic t_no_ccs();
        clear_all();
        issue(0);
        cmd_in = 0; step(); step(); step(); cmd_in = 1;
        check("R8 no wait without flag", {5'd0, raw_status}, 8'h00);
        xfer_done = 1; step(); xfer_done = 0;
        check("R8 xfer_done sets dto", {5'd0, raw_status}, 8'h02);
    endtask

    task automatic t_status_irq();
        irq_en = 3'b101; step();
        check("R10 masked bit no irq", {7'd0, irq}, 8'd0);
        irq_en = 3'b010; step();
        check("R10 enabled bit irq", {7'd0, irq}, 8'd1);
        status_clr = 3'b010; step(); status_clr = 0;
        check("R9 w1c clears", {4'd0, irq, raw_status}, 8'h00);
        xfer_done = 1; status_clr = 3'b010; step(); xfer_done = 0; status_clr = 0;
        check("R9 set wins over clear", {5'd0, raw_status}, 8'h02);
        irq_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1;
        step();
        t_ccs();
        t_ccsd();
        t_same_cycle();
        t_late_ccsd();
        t_autostop();
        t_no_ccs();
        t_status_irq();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule